// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz timebase enable into a programmable periodic tick. A 4-bit rate code selects a period that is a power of two of timebase cycles. Each tick is reported as a one-cycle pulse that sets a periodic flag held elsewhere. The same tick may also raise an interrupt request and a square-wave output pulse, each gated by its own enable. Ticks are not produced by a per-rate down-counter. They fall on exact multiples of the period, counted by a 15-bit free-running timebase counter, so a rate change lines up at once with the new period grid.

The divider-run input holds that counter at zero and stops all ticks. After release, the first tick comes one full period later. The generator is live only while the rate code is nonzero and at least one of the two enables is set. The control inputs are plain levels sampled every clock. No data flows through the block, so it has no valid/ready interface.

Top module: `periodic_rate_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, pf_set, irq_set and sqw_pulse are all 0.
- R2: A rate_code of 0 produces no pulse on any output, whatever the enables are.
- R3: For rate_code values 3 to 15, the period is 2^(rate_code-1) timebase strobes. Ticks fall on strobes where the free-running count reaches a multiple of the period.
- R4: rate_code 1 gives a period of 128 strobes and rate_code 2 gives 256 strobes. These are the same periods as codes 8 and 9.
- R5: With rate_code nonzero but pie_en and sqw_en both 0, no pulse is produced.
- R6: pf_set is high for exactly one clock, namely the clock after the tb_tick cycle on which the tick falls.
- R7: irq_set pulses together with pf_set only if pie_en was 1 on the tick's strobe cycle.
- R8: sqw_pulse pulses together with pf_set only if sqw_en was 1 on the tick's strobe cycle.
- R9: While div_run is 0 the count is held at zero and strobes produce no pulse. After release, the first tick falls on the strobe numbered one period.
- R10: A change of rate_code produces no pulse on the change cycle. The next tick falls at the next multiple of the new period in the running count.
- R11: The count wraps modulo 32768, and ticks continue across the wrap. With rate_code 15 there are ticks at strobe 16384 and strobe 32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_code | input | 4 | Rate select; 0 disables, 1 and 2 alias to slow rates |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| div_run | input | 1 | Divider chain running; 0 holds the count at zero |
| tb_tick | input | 1 | One-cycle 32768 Hz timebase strobe |
| pf_set | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_set | output | 1 | One-cycle interrupt-request set pulse |
| sqw_pulse | output | 1 | One-cycle square-wave output pulse |

## Verification
A wrong count or rate mask shows up as a pulse on the wrong strobe, so the tick spacing drifts from the power-of-two grid. Over a window of a few periods, this appears as a wrong number of pulses. A missing hold on div_run moves the first tick after release to a strobe that is not equal to one period. A count that misses its wrap shows in the second tick at rate code 15. All of these faults appear in the cycle after the affected strobe, because one register separates the strobe from the outputs.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 15;

  // Exponent of the period for a nonzero rate code; low codes fold to slow rates.
  function automatic int rate_shift(input logic [CODE_W-1:0] code);
    int eff;
    eff = (int'(code) <= 2) ? int'(code) + 7 : int'(code);
    return eff - 1;
  endfunction
endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode
  import prg_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NW = CNT_W
) (
  input  logic [CW-1:0] code,
  input  logic          pie_en,
  input  logic          sqw_en,
  output logic          active,
  output logic [NW-1:0] mask
);
  int shift;

  always_comb begin
    shift  = rate_shift(code);
    active = (code != '0) && (pie_en || sqw_en);
  end

  for (genvar i = 0; i < NW; i++) begin : g_mask
    assign mask[i] = (i < shift);
  end
endmodule

// File: rtl/prg_prescaler.sv
module prg_prescaler #(
  parameter int NW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_run,
  input  logic          tb_tick,
  output logic          step,
  output logic [NW-1:0] cnt_next
);
  logic [NW-1:0] cnt_q;

  assign step     = div_run && tb_tick;
  assign cnt_next = cnt_q + NW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!div_run) cnt_q <= '0;
    else if (tb_tick)  cnt_q <= cnt_next;
  end
endmodule

// File: rtl/prg_tick_detect.sv
module prg_tick_detect #(
  parameter int NW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [NW-1:0] cnt_next,
  input  logic [NW-1:0] mask,
  input  logic          active,
  input  logic          pie_en,
  input  logic          sqw_en,
  output logic          pf_set,
  output logic          irq_set,
  output logic          sqw_pulse
);
  logic hit;

  assign hit = step && active && ((cnt_next & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_set    <= 1'b0;
      irq_set   <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      pf_set    <= hit;
      irq_set   <= hit && pie_en;
      sqw_pulse <= hit && sqw_en;
    end
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import prg_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rate_code,
  input  logic          pie_en,
  input  logic          sqw_en,
  input  logic          div_run,
  input  logic          tb_tick,
  output logic          pf_set,
  output logic          irq_set,
  output logic          sqw_pulse
);
  logic          active;
  logic [NW-1:0] mask;
  logic          step;
  logic [NW-1:0] cnt_next;

  prg_rate_decode #(.CW(CW), .NW(NW)) u_dec (
    .code(rate_code), .pie_en(pie_en), .sqw_en(sqw_en),
    .active(active), .mask(mask)
  );

  prg_prescaler #(.NW(NW)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_run(div_run), .tb_tick(tb_tick),
    .step(step), .cnt_next(cnt_next)
  );

  prg_tick_detect #(.NW(NW)) u_det (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt_next(cnt_next),
    .mask(mask), .active(active), .pie_en(pie_en), .sqw_en(sqw_en),
    .pf_set(pf_set), .irq_set(irq_set), .sqw_pulse(sqw_pulse)
  );
endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rate_code,
  input logic          pie_en,
  input logic          sqw_en,
  input logic          div_run,
  input logic          tb_tick,
  input logic          pf_set,
  input logic          irq_set,
  input logic          sqw_pulse
);
  // R9
  pf_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(tb_tick && div_run));
  // R2
  pf_code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> ($past(rate_code) != '0));
  // R5
  pf_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(pie_en || sqw_en));
  // R6
  pf_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |=> !pf_set);
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (pf_set && $past(pie_en)));
  // R8
  sqw_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> (pf_set && $past(sqw_en)));
endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .pie_en(pie_en),
  .sqw_en(sqw_en), .div_run(div_run), .tb_tick(tb_tick),
  .pf_set(pf_set), .irq_set(irq_set), .sqw_pulse(sqw_pulse)
);

// File: tb/periodic_rate_gen_bench.sv
`timescale 1ns/1ps
module periodic_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_code = '0;
  logic       pie_en = 1'b0, sqw_en = 1'b0, div_run = 1'b0, tb_tick = 1'b0;
  logic       pf_set, irq_set, sqw_pulse;

  int checks = 0, errors = 0;
  int n_pf = 0, n_irq = 0, n_sq = 0;
  logic clr = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  periodic_rate_gen u_periodic_rate_gen (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .pie_en(pie_en),
    .sqw_en(sqw_en), .div_run(div_run), .tb_tick(tb_tick),
    .pf_set(pf_set), .irq_set(irq_set), .sqw_pulse(sqw_pulse)
  );

  always @(negedge clk) begin
    if (clr) begin
      n_pf = 0; n_irq = 0; n_sq = 0;
    end else if (rst_n) begin
      if (pf_set)    n_pf++;
      if (irq_set)   n_irq++;
      if (sqw_pulse) n_sq++;
    end
  end

  typedef struct packed {
    logic [3:0]  code;
    logic        pie;
    logic        sqw;
    logic [15:0] n;
    logic [15:0] e_pf;
    logic [15:0] e_irq;
    logic [15:0] e_sq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b1, 1'b0, 16'd20,    16'd5, 16'd5, 16'd0}, // R3 R7 period 4
    '{4'd6,  1'b1, 1'b1, 16'd100,   16'd3, 16'd3, 16'd3}, // R3 R8 period 32
    '{4'd1,  1'b1, 1'b0, 16'd300,   16'd2, 16'd2, 16'd0}, // R4 code 1 -> 128
    '{4'd2,  1'b0, 1'b1, 16'd600,   16'd2, 16'd0, 16'd2}, // R4 R8 code 2 -> 256
    '{4'd0,  1'b1, 1'b1, 16'd50,    16'd0, 16'd0, 16'd0}, // R2 disabled
    '{4'd3,  1'b0, 1'b0, 16'd40,    16'd0, 16'd0, 16'd0}, // R5 no enable
    '{4'd9,  1'b1, 1'b0, 16'd256,   16'd1, 16'd1, 16'd0}, // R4 code 9 -> 256
    '{4'd15, 1'b1, 1'b1, 16'd32768, 16'd2, 16'd2, 16'd2}  // R11 wrap
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // one strobe; returns pf_set as seen in the following cycle
  task automatic strobe(output logic pf_seen);
    @(negedge clk) tb_tick = 1'b1;
    @(negedge clk) tb_tick = 1'b0;
    pf_seen = pf_set;
  endtask

  task automatic strobes(input int n);
    logic s;
    for (int i = 0; i < n; i++) strobe(s);
    @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk) div_run = 1'b0;
    @(negedge clk) div_run = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 pf_set in reset", int'(pf_set), 0);
    check("R1 irq_set in reset", int'(irq_set), 0);
    check("R1 sqw_pulse in reset", int'(sqw_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'({pf_set, irq_set, sqw_pulse}), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      rate_code = VECS[v].code;
      pie_en    = VECS[v].pie;
      sqw_en    = VECS[v].sqw;
      restart();
      clear_counts();
      strobes(int'(VECS[v].n));
      check($sformatf("vector %0d pf count", v), n_pf, int'(VECS[v].e_pf));
      check($sformatf("vector %0d irq count", v), n_irq, int'(VECS[v].e_irq));
      check($sformatf("vector %0d sqw count", v), n_sq, int'(VECS[v].e_sq));
    end

    // R9 hold while divider stopped, first tick one period after release
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b0;
    @(negedge clk) div_run = 1'b0;
    clear_counts();
    strobes(10);
    check("R9 no pulse while held", n_pf, 0);
    @(negedge clk) div_run = 1'b1;
    clear_counts();
    for (int i = 1; i <= 3; i++) begin
      strobe(s);
      check($sformatf("R9 strobe %0d after release", i), int'(s), 0);
    end
    strobe(s);
    check("R9 tick at strobe 4", int'(s), 1);
    @(negedge clk);
    check("R6 pulse one cycle wide", int'(pf_set), 0);

    // R10 rate change aligns to new period grid
    rate_code = 4'd4;
    restart();
    clear_counts();
    strobes(5);
    check("R10 no tick before 8 at code 4", n_pf, 0);
    @(negedge clk) rate_code = 4'd3;
    repeat (2) @(negedge clk);
    check("R10 no tick on change cycle", n_pf, 0);
    strobe(s);
    check("R10 strobe 6 after change", int'(s), 0);
    strobe(s);
    check("R10 strobe 7 after change", int'(s), 0);
    strobe(s);
    check("R10 tick at count 8", int'(s), 1);
    @(negedge clk) rate_code = 4'd5;
    @(negedge clk);
    clear_counts();
    strobes(7);
    check("R10 no tick before count 16", n_pf, 0);
    strobe(s);
    check("R10 tick at count 16", int'(s), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule